// File: doc/BRIEF.md
# Banked Hardware-Monitor Register Window

This block is the register side of a hardware monitor. Software reaches it through two byte ports in an eight-byte I/O window: an index port that selects one of 128 locations, and a data port that reads or writes the selected location. Voltage and temperature readings come in on input ports. They appear at fixed measurement locations, and software cannot overwrite them. A bank field in a configuration register decides whether the eight locations at 0x50–0x57 belong to the local register file or to one of two external sensor register ports.

Some locations advance the index by one after each data access, so block reads and block writes of the value RAM need no index rewrites. Indices 0x60 and up alias onto the lower value-RAM range. A two-byte vendor identifier is read through one location, and a select bit picks which byte it returns. A self-clearing initialisation bit returns every register to its default value. The serial slave address that software last programmed survives this initialisation.

Top module: `hwmon_regwin`

## Requirements
- R1: Only io_addr[2:0] is decoded. Offset 5 is the index port and offset 6 is the data port. A read at any other offset returns 0xFF, and a write there changes nothing.
- R2: The index is 7 bits wide. A write to the index port stores io_wdata[6:0]. A read of the index port returns {0, index}.
- R3: The bank is bits [2:0] of register 0x4E. With bank 1 (or 2), data-port accesses at index 0x50–0x57 go to external port 0 (or 1): ext_rd[0] (or [1]) or ext_wr[0] (or [1]) pulses, ext_addr = index[2:0], and a read returns ext0_rdata (or ext1_rdata). In every other bank these indices are ordinary registers.
- R4: In bank 0, a data-port read or write at index 0x41, 0x43, 0x45, 0x56 or 0x60–0x7F advances the index by one on the next clock, wrapping from 0x7F to 0x00. No other data access changes the index.
- R5: Indices 0x60–0x7F address location (index & 0x3F) for both reads and writes.
- R6: Location 0x20+n (n = 0..6) reads bits [VW-1:VW-8] of voltage input n. Location 0x27 reads temp_in.
- R7: Data writes at index 0x00–0x05, 0x20–0x2A, 0x60–0x6A, 0x41, 0x42, 0x4F and 0x58 leave the register file unchanged.
- R8: Location 0x4F reads byte 0x5C when bit 7 of register 0x4E is set, and byte 0xA3 when it is clear.
- R9: Writing register 0x40 with bit 7 set loads every register with its default value and leaves slave_addr unchanged. Register 0x40 then reads 0x08, and register 0x48 reads the kept slave address.
- R10: A write to register 0x49 stores only bit 0 of the written value. The other bits read as 0.
- R11: A write to register 0x48 sets slave_addr to io_wdata[6:0] on the next clock. The register reads back the full written byte.
- R12: After rst, the index is 0 and slave_addr is 0x2D. The defaults are 0x40=0x08, 0x46=0x40, 0x47=0x50, 0x48=0x2D, 0x49=0x02, 0x4A=0x01, 0x4B=0x44, 0x4C=0x01, 0x4D=0x15, 0x4E=0x80, 0x57=0x80 and 0x58=0x10. Every other stored location is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 3 | Window offset |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| volt_in | input | 7*VW | Seven voltage readings, reading n at bits [n*VW +: VW] |
| temp_in | input | 8 | Primary temperature reading |
| ext_addr | output | 3 | Register select towards the external sensors |
| ext_rd | output | 2 | Read strobe per external sensor |
| ext_wr | output | 2 | Write strobe per external sensor |
| ext_wdata | output | 8 | Write data towards the external sensors |
| ext0_rdata | input | 8 | Read data from external sensor 0 |
| ext1_rdata | input | 8 | Read data from external sensor 1 |
| slave_addr | output | 7 | Current serial slave address |

## Verification
Directed sequences exercise each index class on its own: the auto-advance set against its neighbours, the 0x7F wrap, alias writes read back through their base location, protected locations after a write attempt, and the window under banks 0 to 3. Together they separate an off-by-one in the range decode from a wrong bank choice. A long random run then mixes index moves, bank changes, initialisation writes and input changes. A reference model compares every read. The random run finds faults that appear only in sequences, such as an index advance computed with the bank after the write, or an initialisation that loses the slave address.

// File: rtl/hwmon_regwin.sv
module hwmon_regwin #(
  parameter int          VW        = 12,
  parameter logic [6:0]  SLAVE_DEF = 7'h2D,
  parameter logic [15:0] VENDOR    = 16'h5CA3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  input  logic [7*VW-1:0] volt_in,
  input  logic [7:0]    temp_in,
  output logic [2:0]    ext_addr,
  output logic [1:0]    ext_rd,
  output logic [1:0]    ext_wr,
  output logic [7:0]    ext_wdata,
  input  logic [7:0]    ext0_rdata,
  input  logic [7:0]    ext1_rdata,
  output logic [6:0]    slave_addr
);
  localparam int DEPTH = 128;
  localparam int VLO   = VW - 8;

  logic [7:0] regs [DEPTH];
  logic [6:0] idx;
  logic [7:0] dat;

  wire [2:0] bank     = regs[7'h4E][2:0];
  wire       idx_port = (io_addr == 3'd5);
  wire       dat_port = (io_addr == 3'd6);
  wire       d_rd     = io_rd & dat_port;
  wire       d_wr     = io_wr & dat_port;
  wire       ext_hit  = (idx[6:3] == 4'hA) && (bank == 3'd1 || bank == 3'd2);
  wire [6:0] loc      = (idx >= 7'h60) ? {1'b0, idx[5:0]} : idx;

  wire ro = (idx <= 7'h05) ||
            (idx >= 7'h20 && idx <= 7'h2A) ||
            (idx >= 7'h60 && idx <= 7'h6A) ||
            (idx == 7'h41) || (idx == 7'h42) || (idx == 7'h4F) || (idx == 7'h58);

  wire adv = (bank == 3'd0) &&
             ((idx == 7'h41) || (idx == 7'h43) || (idx == 7'h45) ||
              (idx == 7'h56) || (idx >= 7'h60));

  assign ext_addr  = idx[2:0];
  assign ext_wdata = io_wdata;
  assign ext_rd    = {ext_hit & d_rd & (bank == 3'd2), ext_hit & d_rd & (bank == 3'd1)};
  assign ext_wr    = {ext_hit & d_wr & (bank == 3'd2), ext_hit & d_wr & (bank == 3'd1)};

  function automatic logic [7:0] dflt(input int i, input logic [6:0] sa);
    case (i)
      'h40: dflt = 8'h08;
      'h46: dflt = 8'h40;
      'h47: dflt = 8'h50;
      'h48: dflt = {1'b0, sa};
      'h49: dflt = 8'h02;
      'h4A: dflt = 8'h01;
      'h4B: dflt = 8'h44;
      'h4C: dflt = 8'h01;
      'h4D: dflt = 8'h15;
      'h4E: dflt = 8'h80;
      'h57: dflt = 8'h80;
      'h58: dflt = 8'h10;
      default: dflt = 8'h00;
    endcase
  endfunction

  always_comb begin
    dat = regs[loc];
    if (ext_hit)
      dat = (bank == 3'd2) ? ext1_rdata : ext0_rdata;
    else if (loc >= 7'h20 && loc <= 7'h26)
      dat = volt_in[int'(loc[2:0])*VW + VLO +: 8];
    else if (loc == 7'h27)
      dat = temp_in;
    else if (idx == 7'h4F)
      dat = regs[7'h4E][7] ? VENDOR[15:8] : VENDOR[7:0];
  end

  assign io_rdata = idx_port ? {1'b0, idx} : (dat_port ? dat : 8'hFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      slave_addr <= SLAVE_DEF;
      for (int i = 0; i < DEPTH; i++) regs[i] <= dflt(i, SLAVE_DEF);
    end else begin
      if (io_wr && idx_port)
        idx <= io_wdata[6:0];
      else if ((d_rd || d_wr) && adv)
        idx <= idx + 7'd1;

      if (d_wr && !ext_hit && !ro) begin
        if (loc == 7'h40 && io_wdata[7]) begin
          for (int i = 0; i < DEPTH; i++) regs[i] <= dflt(i, slave_addr);
        end else if (loc == 7'h49) begin
          regs[loc] <= {7'b0, io_wdata[0]};
        end else begin
          regs[loc] <= io_wdata;
          if (loc == 7'h48) slave_addr <= io_wdata[6:0];
        end
      end
    end
  end
endmodule

module hwmon_regwin_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] io_addr,
  input logic       io_wr,
  input logic       io_rd,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic [1:0] ext_rd,
  input logic [1:0] ext_wr,
  input logic [6:0] slave_addr,
  input logic [6:0] idx,
  input logic [2:0] bank
);
  a_r1_other_ff: assert property (@(posedge clk) disable iff (rst)
    (io_addr != 3'd5 && io_addr != 3'd6) |-> io_rdata == 8'hFF);

  a_r2_idx_msb: assert property (@(posedge clk) disable iff (rst)
    (io_addr == 3'd5) |-> !io_rdata[7]);

  a_r3_ext_one: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ext_rd) && $onehot0(ext_wr));

  a_r3_ext_src: assert property (@(posedge clk) disable iff (rst)
    (ext_rd != 2'b00) |-> (io_rd && io_addr == 3'd6 && (bank == 3'd1 || bank == 3'd2)));

  a_r4_adv: assert property (@(posedge clk) disable iff (rst)
    (io_addr == 3'd6 && (io_rd || io_wr) && bank == 3'd0 && idx >= 7'h60)
      |=> idx == $past(idx) + 7'd1);

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (io_addr == 3'd6 && (io_rd || io_wr) && bank != 3'd0) |=> idx == $past(idx));

  a_r9_keep_slave: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == 3'd6 && idx == 7'h40 && io_wdata[7])
      |=> $stable(slave_addr) && bank == 3'd0);
endmodule

bind hwmon_regwin hwmon_regwin_chk chk_i (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .ext_rd(ext_rd), .ext_wr(ext_wr),
  .slave_addr(slave_addr), .idx(idx), .bank(bank)
);

// File: tb/hwmon_regwin_tb.sv
`timescale 1ns/1ps
module hwmon_regwin_tb_top;
  localparam int VW = 12;

  logic clk = 0, rst = 1;
  logic [2:0] io_addr = 0;
  logic io_wr = 0, io_rd = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic [7*VW-1:0] volt_in = '0;
  logic [7:0] temp_in = 0;
  logic [2:0] ext_addr;
  logic [1:0] ext_rd, ext_wr;
  logic [7:0] ext_wdata, ext0_rdata, ext1_rdata;
  logic [6:0] slave_addr;

  always #2.5 clk = ~clk;

  assign ext0_rdata = {5'b10100, ext_addr};
  assign ext1_rdata = {5'b11000, ext_addr};

  hwmon_regwin #(.VW(VW)) dut_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .volt_in(volt_in), .temp_in(temp_in),
    .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_wdata(ext_wdata),
    .ext0_rdata(ext0_rdata), .ext1_rdata(ext1_rdata), .slave_addr(slave_addr)
  );

  logic [7:0] mdl [128];
  logic [6:0] midx, mslave;
  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s idx=%h actual=%h expected=%h", tag, midx, act, exp);
    end
  endtask

  function automatic logic [7:0] m_dflt(input int i, input logic [6:0] sa);
    case (i)
      'h40: return 8'h08;  'h46: return 8'h40;  'h47: return 8'h50;
      'h48: return {1'b0, sa};
      'h49: return 8'h02;  'h4A: return 8'h01;  'h4B: return 8'h44;
      'h4C: return 8'h01;  'h4D: return 8'h15;  'h4E: return 8'h80;
      'h57: return 8'h80;  'h58: return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_init(input logic [6:0] sa);
    for (int i = 0; i < 128; i++) mdl[i] = m_dflt(i, sa);
  endtask

  function automatic bit m_ro(input logic [6:0] i);
    return (i <= 7'h05) || (i >= 7'h20 && i <= 7'h2A) || (i >= 7'h60 && i <= 7'h6A) ||
           i == 7'h41 || i == 7'h42 || i == 7'h4F || i == 7'h58;
  endfunction

  function automatic logic [6:0] m_loc(input logic [6:0] i);
    return (i >= 7'h60) ? (i & 7'h3F) : i;
  endfunction

  function automatic bit m_hit();
    logic [2:0] bk = mdl[7'h4E][2:0];
    return midx[6:3] == 4'hA && (bk == 3'd1 || bk == 3'd2);
  endfunction

  function automatic bit m_adv();
    return mdl[7'h4E][2:0] == 3'd0 &&
      (midx == 7'h41 || midx == 7'h43 || midx == 7'h45 || midx == 7'h56 || midx >= 7'h60);
  endfunction

  function automatic logic [7:0] m_read();
    logic [6:0] l = m_loc(midx);
    if (m_hit()) return (mdl[7'h4E][2:0] == 3'd2) ? {5'b11000, midx[2:0]} : {5'b10100, midx[2:0]};
    if (l >= 7'h20 && l <= 7'h26) return volt_in[int'(l[2:0])*VW + 4 +: 8];
    if (l == 7'h27) return temp_in;
    if (midx == 7'h4F) return mdl[7'h4E][7] ? 8'h5C : 8'hA3;
    return mdl[l];
  endfunction

  function automatic string m_tag();
    logic [6:0] l = m_loc(midx);
    if (m_hit()) return "R3";
    if (l >= 7'h20 && l <= 7'h27) return "R6";
    if (midx == 7'h4F) return "R8";
    if (midx >= 7'h60) return "R5";
    return "R7";
  endfunction

  task automatic op(input string tag, input logic [2:0] a, input logic w, input logic r,
                    input logic [7:0] d);
    logic [7:0] ex;
    logic [1:0] erd, ewr;
    logic [2:0] bk;
    logic [6:0] l;
    bit hit, adv;
    bk  = mdl[7'h4E][2:0];
    hit = (a == 3'd6) && m_hit();
    adv = m_adv();
    ex  = (a == 3'd5) ? {1'b0, midx} : ((a == 3'd6) ? m_read() : 8'hFF);
    erd = {hit && r && bk == 3'd2, hit && r && bk == 3'd1};
    ewr = {hit && w && bk == 3'd2, hit && w && bk == 3'd1};
    @(negedge clk);
    io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
    #1;
    if (r) chk(tag, io_rdata, ex);
    if (a == 3'd6) begin
      chk("R3", {4'b0, ext_rd, ext_wr}, {4'b0, erd, ewr});
      if (hit) chk("R3", {5'b0, ext_addr}, {5'b0, midx[2:0]});
    end
    if (a == 3'd5 && w) midx = d[6:0];
    else if (a == 3'd6) begin
      if (w && !hit && !m_ro(midx)) begin
        l = m_loc(midx);
        if (l == 7'h40 && d[7]) m_init(mslave);
        else if (l == 7'h49) mdl[l] = {7'b0, d[0]};
        else begin
          mdl[l] = d;
          if (l == 7'h48) mslave = d[6:0];
        end
      end
      if ((r || w) && adv) midx = midx + 7'd1;
    end
    @(posedge clk);
    #1;
    io_wr = 0; io_rd = 0;
  endtask

  task automatic seti(input logic [6:0] i);
    op("R2", 3'd5, 1'b1, 1'b0, {1'b0, i});
  endtask

  task automatic chk_slave(input string tag);
    chk(tag, {1'b0, slave_addr}, {1'b0, mslave});
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #1000000;
    nchk++; nfail++;
    $display("FAIL watchdog run did not complete");
    report();
  end

  initial begin
    logic [7:0] ro_list [5];
    void'($urandom(32'd1234));
    for (int i = 0; i < 7; i++) volt_in[i*VW +: VW] = VW'($urandom);
    temp_in = 8'h3B;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    m_init(7'h2D); mslave = 7'h2D; midx = 0;

    // R12 reset state
    op("R12", 3'd5, 1'b0, 1'b1, 8'h00);
    chk_slave("R12");
    seti(7'h4E); op("R12", 3'd6, 1'b0, 1'b1, 8'h00);
    seti(7'h4B); op("R12", 3'd6, 1'b0, 1'b1, 8'h00);
    seti(7'h40); op("R12", 3'd6, 1'b0, 1'b1, 8'h00);

    // R1 other offsets
    op("R1", 3'd0, 1'b0, 1'b1, 8'h00);
    op("R1", 3'd7, 1'b0, 1'b1, 8'h00);
    op("R1", 3'd3, 1'b1, 1'b0, 8'h11);
    op("R1", 3'd5, 1'b0, 1'b1, 8'h00);
    op("R1", 3'd6, 1'b0, 1'b1, 8'h00);

    // R2 index width
    op("R2", 3'd5, 1'b1, 1'b0, 8'hC5);
    op("R2", 3'd5, 1'b0, 1'b1, 8'h00);

    // R4 auto-advance and wrap
    op("R4", 3'd6, 1'b0, 1'b1, 8'h00);
    op("R4", 3'd5, 1'b0, 1'b1, 8'h00);
    op("R4", 3'd6, 1'b0, 1'b1, 8'h00);
    op("R4", 3'd5, 1'b0, 1'b1, 8'h00);
    seti(7'h7F); op("R4", 3'd6, 1'b0, 1'b1, 8'h00);
    op("R4", 3'd5, 1'b0, 1'b1, 8'h00);

    // R5 alias
    seti(7'h70); op("R5", 3'd6, 1'b1, 1'b0, 8'h5A);
    op("R5", 3'd5, 1'b0, 1'b1, 8'h00);
    seti(7'h30); op("R5", 3'd6, 1'b0, 1'b1, 8'h00);

    // R6 measurements
    for (int i = 0; i < 8; i++) begin
      seti(7'h20 + 7'(i)); op("R6", 3'd6, 1'b0, 1'b1, 8'h00);
    end
    seti(7'h64); op("R6", 3'd6, 1'b0, 1'b1, 8'h00);

    // R7 protected locations
    ro_list = '{8'h42, 8'h20, 8'h65, 8'h03, 8'h58};
    for (int k = 0; k < 5; k++) begin
      seti(ro_list[k][6:0]); op("R7", 3'd6, 1'b1, 1'b0, 8'h77);
      seti(ro_list[k][6:0]); op("R7", 3'd6, 1'b0, 1'b1, 8'h00);
    end
    seti(7'h2A); op("R7", 3'd6, 1'b0, 1'b1, 8'h00);

    // R8 vendor bytes
    seti(7'h4F); op("R8", 3'd6, 1'b0, 1'b1, 8'h00);
    seti(7'h4E); op("R8", 3'd6, 1'b1, 1'b0, 8'h00);
    seti(7'h4F); op("R8", 3'd6, 1'b1, 1'b0, 8'h12);
    op("R8", 3'd6, 1'b0, 1'b1, 8'h00);

    // R3 banks
    seti(7'h4E); op("R3", 3'd6, 1'b1, 1'b0, 8'h01);
    seti(7'h52); op("R3", 3'd6, 1'b0, 1'b1, 8'h00);
    seti(7'h55); op("R3", 3'd6, 1'b1, 1'b0, 8'h3C);
    seti(7'h4E); op("R3", 3'd6, 1'b1, 1'b0, 8'h02);
    seti(7'h50); op("R3", 3'd6, 1'b0, 1'b1, 8'h00);
    seti(7'h56); op("R3", 3'd6, 1'b0, 1'b1, 8'h00);
    op("R3", 3'd5, 1'b0, 1'b1, 8'h00);
    seti(7'h4E); op("R3", 3'd6, 1'b1, 1'b0, 8'h03);
    seti(7'h50); op("R3", 3'd6, 1'b1, 1'b0, 8'h99);
    op("R3", 3'd6, 1'b0, 1'b1, 8'h00);

    // R11 slave address
    seti(7'h4E); op("R11", 3'd6, 1'b1, 1'b0, 8'h00);
    seti(7'h48); op("R11", 3'd6, 1'b1, 1'b0, 8'h9A);
    chk_slave("R11");
    op("R11", 3'd6, 1'b0, 1'b1, 8'h00);

    // R10
    seti(7'h49); op("R10", 3'd6, 1'b1, 1'b0, 8'hFF);
    op("R10", 3'd6, 1'b0, 1'b1, 8'h00);

    // R9 initialisation
    seti(7'h4E); op("R9", 3'd6, 1'b1, 1'b0, 8'h01);
    seti(7'h40); op("R9", 3'd6, 1'b1, 1'b0, 8'h80);
    chk_slave("R9");
    op("R9", 3'd6, 1'b0, 1'b1, 8'h00);
    seti(7'h48); op("R9", 3'd6, 1'b0, 1'b1, 8'h00);
    seti(7'h30); op("R9", 3'd6, 1'b0, 1'b1, 8'h00);
    seti(7'h4E); op("R9", 3'd6, 1'b0, 1'b1, 8'h00);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int sel = int'($urandom % 16);
      if ($urandom % 32 == 0) begin
        for (int i = 0; i < 7; i++) volt_in[i*VW +: VW] = VW'($urandom);
        temp_in = 8'($urandom);
      end
      if (sel < 5) begin
        logic [7:0] iv = ($urandom % 2) ? 8'($urandom) : {1'b0, 7'h40 + 7'($urandom % 24)};
        op("R2", 3'd5, 1'b1, ($urandom % 2) == 1, iv);
      end else if (sel < 15) begin
        logic [7:0] d = 8'($urandom);
        bit w = ($urandom % 3) == 0;
        if (midx == 7'h40 && ($urandom % 4) != 0) d[7] = 1'b0;
        if (midx == 7'h4E && ($urandom % 2) == 1) d[2] = 1'b0;
        op(m_tag(), 3'd6, w, !w || ($urandom % 2) == 1, d);
      end else begin
        op("R1", 3'($urandom), ($urandom % 2) == 1, 1'b1, 8'($urandom));
      end
      if (n % 64 == 0) chk_slave("R11");
    end
    op("R2", 3'd5, 1'b0, 1'b1, 8'h00);
    chk_slave("R9");
    report();
  end
endmodule